// File: doc/BRIEF.md
# Serial Pin-Direction Loader

This block holds the per-pin direction settings of a small I/O expander and lets a slow host load them over three lines: a strobe, a serial data input and an active-low sequence clear. Once the sequence is cleared, the host sends a fixed series of strobes. The first N strobes shift data into a shadow register. The next N strobes return the shadow contents on a serial data output so the host can compare them with what it sent. One more strobe then copies the shadow into the active direction register. No address or command bits are used. The position of a strobe in the series decides what it does.

The active register drives the pins' output enables. A global output-enable input gates all of them. All host lines are asynchronous to the block clock and are synchronized inside the block. A strobe takes effect on the rising edge of its synchronized copy. The width N is a parameter from 2 to 64.

Top module: `pindir_loader`

## Requirements
- R1: A low level on clr_n_in clears the strobe count and the shadow register. The first strobe rise after clr_n_in returns high is treated as the first load strobe, whatever strobes came before.
- R2: During the first N strobes after a clear, each strobe rise shifts sdi_in into bit 0 of the shadow and moves the older bits up by one. The first bit sent therefore ends in bit N-1, so words are sent most significant bit first.
- R3: Strobes N+1 to 2N each place one shadow bit on sdo_out, bit N-1 first and bit 0 last. sdo_out holds that bit until the next strobe rise.
- R4: The active direction register keeps its previous value through the load and readback strobes. On strobe 2N+1 it takes the shadow value.
- R5: Strobes after strobe 2N+1 have no effect on the active register or on sdo_out until the next clear.
- R6: A synchronous reset (rst high) sets the active register to all zeros, which makes every pin an input. It also sets pin_oe_out and sdo_out to zero and clears the strobe count.
- R7: clr_n_in never changes the active register or pin_oe_out.
- R8: While oe_glb_in is low, pin_oe_out is all zeros. While it is high, pin_oe_out bit i equals active bit i, where 1 means the pin drives.
- R9: oe_glb_in is synchronous to clk. pin_oe_out follows a change on it after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strb_in | input | 1 | Host strobe, asynchronous; acts on its rising edge |
| sdi_in | input | 1 | Host serial data, asynchronous |
| clr_n_in | input | 1 | Host sequence clear, asynchronous, active low |
| oe_glb_in | input | 1 | Global output-enable gate, synchronous to clk |
| sdo_out | output | 1 | Serial readback of the shadow register |
| pin_oe_out | output | N | Per-pin output enables (1 = drive) |

## Verification
The assertions assume that every host line stays stable for several clock cycles around each change. They also assume that sdi_in is settled before the strobe rises, and that each strobe low and high phase is longer than the synchronizer depth plus one cycle. The bench holds each level of strobe, data and clear for at least four clock cycles. It changes sdi_in only while the strobe is low, and it lowers the strobe before any reset so that the edge detector does not see a false rise. oe_glb_in is driven only on falling clock edges, which keeps it synchronous.

// File: rtl/pindir_pkg.sv
package pindir_pkg;
  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_READ   = 2'd1,
    PH_COMMIT = 2'd2,
    PH_DONE   = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/pindir_sync.sv
module pindir_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pindir_seq.sv
module pindir_seq
  import pindir_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_s,
  input  logic clr_n_s,
  output logic load_en,
  output logic read_en,
  output logic commit_en
);
  localparam int CW = $clog2(2*N + 2);
  localparam logic [CW-1:0] READ_START = CW'(N);
  localparam logic [CW-1:0] COMMIT_CNT = CW'(2*N);
  localparam logic [CW-1:0] DONE_CNT   = CW'(2*N + 1);

  logic          strb_prev_q;
  logic          rise;
  logic [CW-1:0] cnt_q;
  seq_phase_e    phase;

  always_ff @(posedge clk) begin
    if (rst) strb_prev_q <= 1'b0;
    else     strb_prev_q <= strb_s;
  end
  assign rise = strb_s & ~strb_prev_q;

  always_comb begin
    if (cnt_q < READ_START)       phase = PH_LOAD;
    else if (cnt_q < COMMIT_CNT)  phase = PH_READ;
    else if (cnt_q == COMMIT_CNT) phase = PH_COMMIT;
    else                          phase = PH_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !clr_n_s) cnt_q <= '0;
    else if (rise && phase != PH_DONE) cnt_q <= cnt_q + 1'b1;
  end

  assign load_en   = clr_n_s & rise & (phase == PH_LOAD);
  assign read_en   = clr_n_s & rise & (phase == PH_READ);
  assign commit_en = clr_n_s & rise & (phase == PH_COMMIT);

  // R1: clear returns the count to the start of a sequence
  assert_clr_restart_R1: assert property (@(posedge clk) disable iff (rst)
    !clr_n_s |=> cnt_q == '0);
  // R5: count never passes the terminal value
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DONE_CNT);
  // R5: once done, only a clear leaves the terminal state
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == DONE_CNT && clr_n_s) |=> cnt_q == DONE_CNT);
  // R4: at most one phase action per cycle
  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_en, read_en, commit_en}));
endmodule

// File: rtl/pindir_shadow.sv
module pindir_shadow #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load_en,
  input  logic         read_en,
  input  logic         sdi_s,
  output logic [N-1:0] shadow_q,
  output logic         sdo_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)   shadow_q <= '0;
    else if (load_en) shadow_q <= {shadow_q[N-2:0], sdi_s};
    else if (read_en) shadow_q <= {shadow_q[N-2:0], shadow_q[N-1]};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   sdo_q <= 1'b0;
    else if (read_en) sdo_q <= shadow_q[N-1];
  end

  // R2: a load strobe moves the word up and takes the new bit at bit 0
  assert_load_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && !clr) |=> (shadow_q[0] == $past(sdi_s)) &&
                          (shadow_q[N-1:1] == $past(shadow_q[N-2:0])));
  // R3: each readback strobe presents the current top bit
  assert_readback_msb_R3: assert property (@(posedge clk) disable iff (rst)
    (read_en && !clr) |=> sdo_q == $past(shadow_q[N-1]));
  // R3: output holds between readback strobes
  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!read_en && !clr) |=> $stable(sdo_q));
endmodule

// File: rtl/pindir_loader.sv
module pindir_loader #(
  parameter int N           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strb_in,
  input  logic         sdi_in,
  input  logic         clr_n_in,
  input  logic         oe_glb_in,
  output logic         sdo_out,
  output logic [N-1:0] pin_oe_out
);
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]   host_s;
  logic         strb_s, sdi_s, clr_n_s;
  logic         load_en, read_en, commit_en;
  logic [N-1:0] shadow_q;
  logic [N-1:0] active_q;
  logic [N-1:0] pin_oe_q;

  initial begin
    if (N < 2 || N > 64) $error("pindir_loader: N must be 2..64");
  end

  pindir_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({clr_n_in, sdi_in, strb_in}),
    .q_out (host_s)
  );
  assign {clr_n_s, sdi_s, strb_s} = host_s;

  pindir_seq #(.N(N)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .strb_s    (strb_s),
    .clr_n_s   (clr_n_s),
    .load_en   (load_en),
    .read_en   (read_en),
    .commit_en (commit_en)
  );

  pindir_shadow #(.N(N)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .clr      (~clr_n_s),
    .load_en  (load_en),
    .read_en  (read_en),
    .sdi_s    (sdi_s),
    .shadow_q (shadow_q),
    .sdo_q    (sdo_out)
  );

  always_ff @(posedge clk) begin
    if (rst)            active_q <= '0;
    else if (commit_en) active_q <= shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_oe_q <= '0;
    else     pin_oe_q <= oe_glb_in ? active_q : '0;
  end
  assign pin_oe_out = pin_oe_q;

  // R4: the active set changes only on the commit strobe
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(active_q));
  // R4: commit copies the shadow word
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> active_q == $past(shadow_q));
  // R8: gate low forces all enables off
  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !oe_glb_in |=> pin_oe_out == '0);
  // R8: gate high passes the active set
  assert_oe_pass_R8: assert property (@(posedge clk) disable iff (rst)
    oe_glb_in |=> pin_oe_out == $past(active_q));
endmodule

// File: tb/pindir_loader_tb_top.sv
module pindir_loader_tb_top;
  localparam int N      = 16;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 5;
  // {global oe, pattern}
  localparam logic [N:0] VEC [NVEC] = '{
    {1'b1, 16'hA5C3}, {1'b1, 16'hFFFF}, {1'b1, 16'h0001},
    {1'b0, 16'h8000}, {1'b1, 16'h3C96}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strb = 1'b0, sdi = 1'b0, clr_n = 1'b1, oe = 1'b1;
  logic sdo;
  logic [N-1:0] pin_oe;
  logic [N-1:0] model_act = '0;
  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  pindir_loader #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .strb_in(strb), .sdi_in(sdi),
    .clr_n_in(clr_n), .oe_glb_in(oe), .sdo_out(sdo), .pin_oe_out(pin_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic d);
    @(negedge clk);
    strb = 1'b0;
    sdi  = d;
    wait_n(4);
    strb = 1'b1;
    wait_n(6);
  endtask

  task automatic clear_seq();
    @(negedge clk);
    clr_n = 1'b0;
    wait_n(4);
    clr_n = 1'b1;
    wait_n(4);
  endtask

  task automatic load_word(input logic [N-1:0] w);
    for (int i = N-1; i >= 0; i--) strobe(w[i]);
  endtask

  task automatic read_word(output logic [N-1:0] w);
    for (int i = N-1; i >= 0; i--) begin
      strobe(1'b0);
      w[i] = sdo;
    end
  endtask

  task automatic commit();
    strobe(1'b0);
    wait_n(4);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] rb;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    // R6: reset state
    chk("R6 pin_oe after reset", 64'(pin_oe), 64'(0));
    chk("R6 sdo after reset", 64'(sdo), 64'(0));

    for (int v = 0; v < NVEC; v++) begin
      logic [N-1:0] pat;
      pat = VEC[v][N-1:0];
      oe  = VEC[v][N];
      clear_seq();
      load_word(pat);
      read_word(rb);
      chk("R2/R3 readback", 64'(rb), 64'(pat));
      // R4: nothing committed yet
      chk("R4 hold before commit", 64'(pin_oe), 64'(oe ? model_act : '0));
      commit();
      model_act = pat;
      chk("R4/R8 after commit", 64'(pin_oe), 64'(oe ? model_act : '0));
      if (!oe) begin
        @(negedge clk); oe = 1'b1;
        wait_n(2);
        chk("R8 gate reopened", 64'(pin_oe), 64'(model_act));
      end
    end

    // R5: extra strobes after commit are ignored
    strobe(1'b1); strobe(1'b1); strobe(1'b0);
    wait_n(4);
    chk("R5 active unchanged", 64'(pin_oe), 64'(model_act));
    chk("R5 sdo unchanged", 64'(sdo), 64'(model_act[0]));

    // R7: clear leaves active untouched
    clear_seq();
    chk("R7 clear keeps active", 64'(pin_oe), 64'(model_act));

    // R1: partial load, clear, fresh full load
    load_word(16'h0000);
    clear_seq();
    strobe(1'b1); strobe(1'b0); strobe(1'b1);
    clear_seq();
    load_word(16'h5A0F);
    read_word(rb);
    chk("R1 restart after clear", 64'(rb), 64'h5A0F);
    commit();
    model_act = 16'h5A0F;
    chk("R1 commit after restart", 64'(pin_oe), 64'(model_act));

    // R9 / R8: one-edge latency of gate
    @(negedge clk); oe = 1'b0;
    @(negedge clk);
    chk("R9 gate off after one edge", 64'(pin_oe), 64'(0));
    oe = 1'b1;
    @(negedge clk);
    chk("R9 gate on after one edge", 64'(pin_oe), 64'(model_act));

    // R6: reset mid-run
    @(negedge clk); strb = 1'b0;
    wait_n(4);
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(3);
    chk("R6 active cleared by reset", 64'(pin_oe), 64'(0));
    chk("R6 sdo cleared by reset", 64'(sdo), 64'(0));
    model_act = '0;
    load_word(16'hC003);
    read_word(rb);
    chk("R6 count cleared by reset", 64'(rb), 64'hC003);

    finish_run();
  end
endmodule